// File: doc/BRIEF.md
# Segment Bus Arbiter with Owner Parking

This block arbitrates a shared parallel bus segment among nine external slots (index 0 to 8) and the bridge's own requester (index 9). Slot requests and grants at the pins are active low; the bridge's request and grant are plain active-high internal signals. When no one asks for the bus, the grant stays with whoever held it last. An optional configuration input sends an idle bus back to the bridge. The grant can move only on a clock edge where the bus is idle, which means both `frame_n` and `irdy_n` are high.

A strap input selects who arbitrates. When the strap is low, this block is the arbiter. When it is high, an outside arbiter owns the segment. The slot-0 grant pin then carries the bridge's request outward, and the slot-0 request pin carries the incoming grant back. In that mode all other slot pins are unused. The block has no data stream, so every pin is a plain control or status level.

Top module: `segment_arbiter`

## Requirements
- R1: While `rst_n` is low and the strap is low, `owner_idx` is 9, `br_gnt` is 1, every `slot_gnt_n` bit is 1, and `parked_at_bridge` is 1.
- R2: With the strap low, exactly one grant is active at all times. Slot i is granted when `slot_gnt_n[i]` is 0, and the bridge is granted when `br_gnt` is 1.
- R3: With the strap low, the owner does not change on an edge where `frame_n` or `irdy_n` is low.
- R4: On an idle edge with any request pending, the new owner is the first requester found by scanning upward from the current owner plus one. The scan runs through index 9 (the bridge) and then wraps to index 0.
- R5: On an idle edge with no requests pending and `park_at_bridge_cfg` low, the owner and `parked_at_bridge` keep their values.
- R6: On an idle edge with no requests pending and `park_at_bridge_cfg` high, the bridge becomes owner and `parked_at_bridge` becomes 1 after that edge.
- R7: An owner that is the only requester keeps the grant.
- R8: With the strap high, `slot_gnt_n[8:1]` stay at 1, and `slot_req_n[8:1]` have no effect on any output.
- R9: With the strap high, `slot_gnt_n[0]` equals the inverse of `br_req` as sampled on the previous edge.
- R10: With the strap high, `br_gnt` becomes 1 one edge after an edge that samples `slot_req_n[0]` low while `slot_gnt_n[0]` is low. Otherwise `br_gnt` becomes 0.
- R11: With the strap high, `parked_at_bridge` becomes 1 after an edge that sees all of the following: `slot_req_n[0]` low, `slot_gnt_n[0]` high, and the bus idle. After any other edge it becomes 0.
- R12: With the strap low, `parked_at_bridge` clears on any idle edge that awards the grant to a requester, including the bridge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| central_strap | input | 1 | 0: this block arbitrates; 1: an outside arbiter does |
| park_at_bridge_cfg | input | 1 | Send an idle, unrequested bus to the bridge |
| frame_n | input | 1 | Bus frame signal, active low |
| irdy_n | input | 1 | Bus initiator-ready signal, active low |
| slot_req_n | input | 9 | Slot requests, active low; bit 0 is the incoming grant when the strap is high |
| slot_gnt_n | output | 9 | Slot grants, active low; bit 0 is the outbound request when the strap is high |
| br_req | input | 1 | Bridge requests the bus |
| br_gnt | output | 1 | Bridge holds the bus |
| owner_idx | output | 4 | Current owner index (9 = bridge) |
| parked_at_bridge | output | 1 | Bridge holds the bus without having asked for it |

## Verification
The properties assume the strap is a static level that changes only while reset is asserted. A property that spans one edge in one mode would be meaningless across a mode change. Requests, the configuration bit and the two bus-activity inputs are treated as free levels that are sampled at the rising edge. The stimulus therefore changes the strap only inside a reset pulse and moves every other input on the falling edge. The idle-parking property also assumes that no request is pending, and the bench supplies that case explicitly by releasing every request line.

// File: rtl/seg_arb_pkg.sv
package seg_arb_pkg;

  typedef enum logic {
    MODE_INTERNAL = 1'b0,
    MODE_EXTERNAL = 1'b1
  } arb_mode_e;

endpackage

// File: rtl/seg_arb_req_cond.sv
// Turns the active-low slot pins and the bridge request into one active-high
// request vector. Every request is masked while an outside arbiter is in charge.
module seg_arb_req_cond
  import seg_arb_pkg::*;
#(
  parameter int N_SLOTS = 9,
  localparam int NREQ = N_SLOTS + 1
) (
  input  arb_mode_e          mode,
  input  logic [N_SLOTS-1:0] slot_req_n,
  input  logic               br_req,
  output logic [NREQ-1:0]    req_vec
);

  logic local_mode;
  assign local_mode = (mode == MODE_INTERNAL);

  generate
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
      assign req_vec[i] = local_mode & ~slot_req_n[i];
    end
  endgenerate

  assign req_vec[NREQ-1] = local_mode & br_req;

endmodule

// File: rtl/seg_arb_rr_pick.sv
// Round-robin scan that starts one place after the current owner and wraps.
// The owner itself is the last candidate, so it is chosen only when nobody else asks.
module seg_arb_rr_pick #(
  parameter int NREQ  = 10,
  parameter int IDX_W = 4
) (
  input  logic [NREQ-1:0]  req_vec,
  input  logic [IDX_W-1:0] owner,
  output logic [IDX_W-1:0] winner,
  output logic             any_req
);

  logic [IDX_W:0] cand;
  logic           found;

  always_comb begin
    winner  = owner;
    found   = 1'b0;
    cand    = '0;
    any_req = |req_vec;
    for (int k = 1; k <= NREQ; k++) begin
      cand = {1'b0, owner} + (IDX_W+1)'(k);
      if (cand >= (IDX_W+1)'(NREQ)) cand = cand - (IDX_W+1)'(NREQ);
      if (!found && req_vec[cand[IDX_W-1:0]]) begin
        found  = 1'b1;
        winner = cand[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/seg_arb_ext_link.sv
// Request/grant exchange with an outside arbiter over the two repurposed slot-0 pins.
module seg_arb_ext_link (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic br_req,
  input  logic gnt_in_n,
  input  logic bus_idle,
  output logic out_req_n,
  output logic br_gnt,
  output logic parked
);

  logic req_r, gnt_r, park_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_r  <= 1'b0;
      gnt_r  <= 1'b0;
      park_r <= 1'b0;
    end else if (!active) begin
      req_r  <= 1'b0;
      gnt_r  <= 1'b0;
      park_r <= 1'b0;
    end else begin
      // R9: the outbound request pin follows br_req one edge later
      req_r  <= br_req;
      // R10: the bridge is granted only when the grant answers a request already on the pin
      gnt_r  <= req_r & ~gnt_in_n;
      // R11: granted, not asking, and the bus is idle: the bridge parks the bus
      park_r <= ~gnt_in_n & ~req_r & bus_idle;
    end
  end

  assign out_req_n = ~req_r;
  assign br_gnt    = gnt_r;
  assign parked    = park_r;

endmodule

// File: rtl/segment_arbiter.sv
module segment_arbiter
  import seg_arb_pkg::*;
#(
  parameter int N_SLOTS = 9,
  localparam int NREQ  = N_SLOTS + 1,
  localparam int IDX_W = $clog2(NREQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               central_strap,
  input  logic               park_at_bridge_cfg,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic [N_SLOTS-1:0] slot_req_n,
  output logic [N_SLOTS-1:0] slot_gnt_n,
  input  logic               br_req,
  output logic               br_gnt,
  output logic [IDX_W-1:0]   owner_idx,
  output logic               parked_at_bridge
);

  localparam logic [IDX_W-1:0] BR_IDX = IDX_W'(N_SLOTS);

  arb_mode_e        mode;
  logic             bus_idle;
  logic             ext_mode;
  logic [NREQ-1:0]  req_vec;
  logic [IDX_W-1:0] winner;
  logic             any_req;
  logic [IDX_W-1:0] owner_r;
  logic             park_r;
  logic             ext_out_req_n, ext_br_gnt, ext_parked;

  assign mode     = arb_mode_e'(central_strap);
  assign ext_mode = (mode == MODE_EXTERNAL);
  assign bus_idle = frame_n & irdy_n;

  seg_arb_req_cond #(.N_SLOTS(N_SLOTS)) u_req_cond (
    .mode       (mode),
    .slot_req_n (slot_req_n),
    .br_req     (br_req),
    .req_vec    (req_vec)
  );

  seg_arb_rr_pick #(.NREQ(NREQ), .IDX_W(IDX_W)) u_rr_pick (
    .req_vec (req_vec),
    .owner   (owner_r),
    .winner  (winner),
    .any_req (any_req)
  );

  seg_arb_ext_link u_ext_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (ext_mode),
    .br_req    (br_req),
    .gnt_in_n  (slot_req_n[0]),
    .bus_idle  (bus_idle),
    .out_req_n (ext_out_req_n),
    .br_gnt    (ext_br_gnt),
    .parked    (ext_parked)
  );

  // Owner register. R1 sets the reset owner, R3 holds it while the bus is busy,
  // R5 keeps the last owner when nobody asks, and R6 forces an idle bus to the bridge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_r <= BR_IDX;
      park_r  <= 1'b1;
    end else if (ext_mode) begin
      owner_r <= BR_IDX;
      park_r  <= 1'b0;
    end else if (bus_idle) begin
      if (any_req) begin
        owner_r <= winner;
        park_r  <= 1'b0;
      end else if (park_at_bridge_cfg) begin
        owner_r <= BR_IDX;
        park_r  <= 1'b1;
      end
    end
  end

  // Grant decode. With the strap low exactly one grant is active (R2).
  // With the strap high slot 0 carries the outbound request (R9) and the other slots stay high (R8).
  generate
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_gnt
      if (i == 0) begin : g_shared
        assign slot_gnt_n[i] = ext_mode ? ext_out_req_n : (owner_r != IDX_W'(i));
      end else begin : g_plain
        assign slot_gnt_n[i] = ext_mode ? 1'b1 : (owner_r != IDX_W'(i));
      end
    end
  endgenerate

  assign br_gnt           = ext_mode ? ext_br_gnt : (owner_r == BR_IDX);
  assign parked_at_bridge = ext_mode ? ext_parked : park_r;
  assign owner_idx        = owner_r;

endmodule

// File: rtl/seg_arb_chk.sv
module seg_arb_chk #(
  parameter int N_SLOTS = 9,
  localparam int NREQ  = N_SLOTS + 1,
  localparam int IDX_W = $clog2(NREQ)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               central_strap,
  input logic               park_at_bridge_cfg,
  input logic               frame_n,
  input logic               irdy_n,
  input logic [N_SLOTS-1:0] slot_req_n,
  input logic [N_SLOTS-1:0] slot_gnt_n,
  input logic               br_req,
  input logic               br_gnt,
  input logic [IDX_W-1:0]   owner_idx,
  input logic               parked_at_bridge
);

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !central_strap |-> ($countones({~slot_gnt_n, br_gnt}) == 1));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!central_strap && !(frame_n && irdy_n)) |=> $stable(owner_idx));

  // R6
  idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!central_strap && park_at_bridge_cfg && frame_n && irdy_n && (&slot_req_n) && !br_req)
      |=> (parked_at_bridge && br_gnt));

  // R8
  ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    central_strap |-> (&slot_gnt_n[N_SLOTS-1:1]));

  // R9
  ext_req_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    central_strap |=> (!central_strap || (slot_gnt_n[0] == !$past(br_req))));

  // R10
  ext_grant_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (central_strap && br_gnt) |-> $past(!slot_req_n[0] && !slot_gnt_n[0]));

endmodule

bind segment_arbiter seg_arb_chk #(.N_SLOTS(N_SLOTS)) u_seg_arb_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .central_strap      (central_strap),
  .park_at_bridge_cfg (park_at_bridge_cfg),
  .frame_n            (frame_n),
  .irdy_n             (irdy_n),
  .slot_req_n         (slot_req_n),
  .slot_gnt_n         (slot_gnt_n),
  .br_req             (br_req),
  .br_gnt             (br_gnt),
  .owner_idx          (owner_idx),
  .parked_at_bridge   (parked_at_bridge)
);

// File: tb/segment_arbiter_bench.sv
`timescale 1ns/1ps
module segment_arbiter_bench;

  localparam int N_SLOTS = 9;
  localparam int NVEC = 17;

  logic clk, rst_n, central_strap, park_at_bridge_cfg, frame_n, irdy_n, br_req;
  logic [N_SLOTS-1:0] slot_req_n, slot_gnt_n;
  logic br_gnt, parked_at_bridge;
  logic [3:0] owner_idx;

  int n_cmp = 0;
  int n_bad = 0;

  segment_arbiter #(.N_SLOTS(N_SLOTS)) u_segment_arbiter (
    .clk(clk), .rst_n(rst_n), .central_strap(central_strap),
    .park_at_bridge_cfg(park_at_bridge_cfg), .frame_n(frame_n), .irdy_n(irdy_n),
    .slot_req_n(slot_req_n), .slot_gnt_n(slot_gnt_n), .br_req(br_req),
    .br_gnt(br_gnt), .owner_idx(owner_idx), .parked_at_bridge(parked_at_bridge)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N_SLOTS-1:0] gnt_pattern(input int owner);
    if (owner < N_SLOTS) return ~(9'b1 << owner);
    return '1;
  endfunction

  // Vector fields: req_n[17:9] br_req[8] frame_busy[7] irdy_busy[6] cfg[5] owner[4:1] parked[0]
  localparam logic [17:0] VEC [NVEC] = '{
    {9'h1FF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9, 1'b1},
    {9'h1F7, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0},
    {9'h1D7, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 1'b0},
    {9'h1D7, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5, 1'b0},
    {9'h1D7, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0},
    {9'h1F7, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0},
    {9'h1FF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0},
    {9'h1FD, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9, 1'b0},
    {9'h1FD, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0},
    {9'h0FE, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0},
    {9'h0FE, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8, 1'b0},
    {9'h0FE, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    {9'h1FF, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0},
    {9'h1FF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9, 1'b1},
    {9'h1FF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9, 1'b1},
    {9'h1FF, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9, 1'b0},
    {9'h1FB, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0}
  };

  localparam string TAGS [NVEC] = '{
    "R5 idle keep", "R4 wrap from bridge", "R4 next after owner", "R3 frame busy",
    "R4 wrap past owner", "R7 lone owner", "R5 last master", "R4 bridge in scan",
    "R4 wrap to slot", "R3 irdy busy", "R4 upward scan", "R4 wrap to zero",
    "R3 both busy", "R6 cfg park", "R5 parked stays", "R12 bridge awarded",
    "R4 from bridge"
  };

  initial begin
    rst_n = 1'b0; central_strap = 1'b0; park_at_bridge_cfg = 1'b0;
    frame_n = 1'b1; irdy_n = 1'b1; br_req = 1'b0; slot_req_n = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 owner", 32'(owner_idx), 32'd9);
    check("R1 br_gnt", 32'(br_gnt), 32'd1);
    check("R1 slot_gnt_n", 32'(slot_gnt_n), 32'h1FF);
    check("R1 parked", 32'(parked_at_bridge), 32'd1);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      slot_req_n         = VEC[v][17:9];
      br_req             = VEC[v][8];
      frame_n            = ~VEC[v][7];
      irdy_n             = ~VEC[v][6];
      park_at_bridge_cfg = VEC[v][5];
      @(negedge clk);
      check({TAGS[v], " owner"}, 32'(owner_idx), 32'(VEC[v][4:1]));
      check({TAGS[v], " parked"}, 32'(parked_at_bridge), 32'(VEC[v][0]));
      check({TAGS[v], " R2 slot grants"}, 32'(slot_gnt_n), 32'(gnt_pattern(int'(VEC[v][4:1]))));
      check({TAGS[v], " R2 bridge grant"}, 32'(br_gnt), 32'(VEC[v][4:1] == 4'd9));
    end

    // Outside-arbiter mode: the strap changes only inside reset
    rst_n = 1'b0; central_strap = 1'b1; park_at_bridge_cfg = 1'b0;
    br_req = 1'b0; slot_req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    slot_req_n = 9'h001;                       // slots 8..1 asking, no incoming grant
    @(negedge clk);
    check("R8 grants held high", 32'(slot_gnt_n), 32'h1FF);
    check("R10 no grant", 32'(br_gnt), 32'd0);
    check("R11 not parked", 32'(parked_at_bridge), 32'd0);

    br_req = 1'b1;
    @(negedge clk);
    check("R9 request out", 32'(slot_gnt_n), 32'h1FE);
    check("R10 grant waits", 32'(br_gnt), 32'd0);

    slot_req_n = 9'h000;                       // incoming grant low
    @(negedge clk);
    check("R10 grant in", 32'(br_gnt), 32'd1);
    check("R11 asking not parked", 32'(parked_at_bridge), 32'd0);

    br_req = 1'b0;
    @(negedge clk);
    check("R9 request dropped", 32'(slot_gnt_n), 32'h1FF);
    check("R10 grant lag", 32'(br_gnt), 32'd1);
    @(negedge clk);
    check("R10 grant released", 32'(br_gnt), 32'd0);
    check("R11 parked", 32'(parked_at_bridge), 32'd1);

    frame_n = 1'b0;
    @(negedge clk);
    check("R11 busy unpark", 32'(parked_at_bridge), 32'd0);
    frame_n = 1'b1;
    @(negedge clk);
    check("R11 idle repark", 32'(parked_at_bridge), 32'd1);
    slot_req_n = 9'h1FF;
    @(negedge clk);
    check("R11 grant withdrawn", 32'(parked_at_bridge), 32'd0);
    check("R8 still high", 32'(slot_gnt_n), 32'h1FF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule